// File: doc/BRIEF.md
# Quasi-bidirectional GPIO port controller

This block is one 8-bit general-purpose port of an 8051-style microcontroller. It has no direction register. The core writes a port output latch, either as a whole byte or one bit at a time (set or clear at a 3-bit index). Each latch bit sets that pin's pad controls. A 0 turns on the pull-down, which pulls the pin low. A 1 releases the pin to its pull-ups, and the pin can then be read as an input. Software makes a pin an input by writing a 1 to it. It can switch a pin between driving and sensing at any time.

Pad inputs pass through a two-stage synchronizer. A 1-bit read-type flag from the core selects what a read returns. A read that belongs to a read-modify-write access to this port returns the latch contents. Any other read returns the synchronized pin level, masked to 0 wherever the pull-down is on. The strong pull-up follows the observed pin. It is on while the latch is 1 and the pin is seen high. It turns off on its own when an external device pulls the pin low, which leaves only the weak pull-up. It comes back once the pin is seen high again. Read data is registered and holds between read strobes.

Top module: `qbio_port`

## Requirements
- R1: After reset the latch holds all ones. Every pin then has its weak pull-up on and its pull-down off, and `rd_data` is 0.
- R2: A write with `wr_op`=0 (byte) loads `wr_data` into the latch at the next clock edge.
- R3: A write with `wr_op`=1 sets latch bit `wr_idx`, and `wr_op`=2 clears it. No other latch bit changes.
- R4: `wr_op`=3, or `wr_en` low, leaves the latch unchanged.
- R5: For each pin, `pad_pd_en` is the inverse of the latch bit and `pad_pu_weak_en` equals the latch bit. No pull-up is on for a pin whose pull-down is on.
- R6: The strong pull-up of a pin is on exactly when its latch bit is 1 and its synchronized pin level is 1. It drops when the pin is seen low and returns when the pin is seen high again.
- R7: A read strobe with `rd_rmw`=1 puts the latch value on `rd_data` one clock later.
- R8: A read strobe with `rd_rmw`=0 puts the synchronized pin level AND the latch on `rd_data` one clock later. A pin whose latch bit is 0 reads 0 whatever is driven.
- R9: A change on `pad_in` reaches plain reads after two clock edges. Strobes sampled at the first and second edges after the change still return the old level. A strobe at the third edge returns the new level.
- R10: `rd_data` holds its value while `rd_en` is low, even if the pins or the latch change.
- R11: A read in the same cycle as a write returns the latch value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Latch write strobe |
| wr_op | input | 2 | 0 byte, 1 bit set, 2 bit clear, 3 no operation |
| wr_data | input | 8 | Byte write data |
| wr_idx | input | 3 | Bit index for set and clear |
| rd_en | input | 1 | Read strobe |
| rd_rmw | input | 1 | Read is part of a read-modify-write to this port |
| rd_data | output | 8 | Registered read data |
| pad_in | input | 8 | Raw pin levels from the pads |
| pad_pd_en | output | 8 | Pull-down enable per pin |
| pad_pu_strong_en | output | 8 | Strong pull-up enable per pin |
| pad_pu_weak_en | output | 8 | Weak pull-up enable per pin |

## Verification
The bench builds the block with its defaults: 8 pins and a two-stage synchronizer. At that size it can write all 256 latch values and pair each with sixteen pin patterns. For every pair it checks the pad enables and both read types. A sweep over all eight indices covers bit set and clear from varied starting bytes. Directed sequences pin down the two-edge synchronizer latency, the drop and return of the strong pull-up, the no-operation write code, holding between strobes, and a read that coincides with a write.

// File: rtl/qbio_pkg.sv
package qbio_pkg;

  typedef enum logic [1:0] {
    QB_WR_BYTE = 2'd0,
    QB_WR_SET  = 2'd1,
    QB_WR_CLR  = 2'd2,
    QB_WR_NOP  = 2'd3
  } qb_wr_op_e;

endpackage

// File: rtl/qbio_sync.sv
module qbio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  localparam logic [WIDTH-1:0] IDLE_LVL = {WIDTH{1'b1}};

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= IDLE_LVL;
    end else begin
      stage_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/qbio_latch.sv
module qbio_latch
  import qbio_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  qb_wr_op_e        wr_op,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [IDX_W-1:0] wr_idx,
  output logic [WIDTH-1:0] latch_q
);

  localparam logic [WIDTH-1:0] RESET_VAL = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE_HOT0  = {{(WIDTH-1){1'b0}}, 1'b1};

  function automatic logic [WIDTH-1:0] bit_mask(input logic [IDX_W-1:0] idx);
    return ONE_HOT0 << idx;
  endfunction

  function automatic logic [WIDTH-1:0] next_latch(
    input logic [WIDTH-1:0] cur,
    input qb_wr_op_e        op,
    input logic [WIDTH-1:0] data,
    input logic [IDX_W-1:0] idx
  );
    case (op)
      QB_WR_BYTE: return data;
      QB_WR_SET:  return cur | bit_mask(idx);
      QB_WR_CLR:  return cur & ~bit_mask(idx);
      default:    return cur;
    endcase
  endfunction

  logic             wr_fire;
  logic             bit_wr;
  logic [WIDTH-1:0] latch_d;

  assign wr_fire = wr_en && (wr_op != QB_WR_NOP);
  assign bit_wr  = wr_en && ((wr_op == QB_WR_SET) || (wr_op == QB_WR_CLR));
  assign latch_d = next_latch(latch_q, wr_op, wr_data, wr_idx);

  always_ff @(posedge clk) begin
    if (!rst_n)       latch_q <= RESET_VAL;
    else if (wr_fire) latch_q <= latch_d;
  end

  assert_byte_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == QB_WR_BYTE) |=> (latch_q == $past(wr_data)));

  assert_bit_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_wr |=> (((latch_q ^ $past(latch_q)) & ~bit_mask($past(wr_idx))) == '0));

  assert_set_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == QB_WR_SET) |=> ((latch_q & bit_mask($past(wr_idx))) == bit_mask($past(wr_idx))));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(latch_q));

endmodule

// File: rtl/qbio_pad_ctrl.sv
module qbio_pad_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] pin_sync,
  output logic [WIDTH-1:0] pd_en,
  output logic [WIDTH-1:0] pu_strong_en,
  output logic [WIDTH-1:0] pu_weak_en
);

  function automatic logic [2:0] pin_drive(input logic lat, input logic seen_hi);
    // {pull-down, strong pull-up, weak pull-up}
    return lat ? {1'b0, seen_hi, 1'b1} : 3'b100;
  endfunction

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic [2:0] drv;
    assign drv             = pin_drive(latch_q[i], pin_sync[i]);
    assign pd_en[i]        = drv[2];
    assign pu_strong_en[i] = drv[1];
    assign pu_weak_en[i]   = drv[0];
  end

endmodule

// File: rtl/qbio_rdpath.sv
module qbio_rdpath #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             rd_rmw,
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] pin_sync,
  output logic [WIDTH-1:0] rd_data
);

  function automatic logic [WIDTH-1:0] pin_view(
    input logic [WIDTH-1:0] lat,
    input logic [WIDTH-1:0] pin
  );
    return lat & pin;
  endfunction

  logic [WIDTH-1:0] rd_sel;
  assign rd_sel = rd_rmw ? latch_q : pin_view(latch_q, pin_sync);

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_sel;
  end

  assert_rmw_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_rmw) |=> (rd_data == $past(latch_q)));

  assert_pin_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_rmw) |=> ((rd_data & ~$past(latch_q)) == '0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/qbio_port.sv
module qbio_port
  import qbio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_op,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             rd_en,
  input  logic             rd_rmw,
  output logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_pd_en,
  output logic [WIDTH-1:0] pad_pu_strong_en,
  output logic [WIDTH-1:0] pad_pu_weak_en
);

  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] pin_sync;
  qb_wr_op_e        wr_op_e;

  assign wr_op_e = qb_wr_op_e'(wr_op);

  qbio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (pin_sync)
  );

  qbio_latch #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_op   (wr_op_e),
    .wr_data (wr_data),
    .wr_idx  (wr_idx),
    .latch_q (latch_q)
  );

  qbio_pad_ctrl #(.WIDTH(WIDTH)) u_pad (
    .latch_q      (latch_q),
    .pin_sync     (pin_sync),
    .pd_en        (pad_pd_en),
    .pu_strong_en (pad_pu_strong_en),
    .pu_weak_en   (pad_pu_weak_en)
  );

  qbio_rdpath #(.WIDTH(WIDTH)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_rmw   (rd_rmw),
    .latch_q  (latch_q),
    .pin_sync (pin_sync),
    .rd_data  (rd_data)
  );

  assert_pd_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pd_en & (pad_pu_strong_en | pad_pu_weak_en)) == '0));

  assert_strong_needs_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu_strong_en & ~pin_sync) == '0));

  assert_weak_tracks_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu_weak_en == latch_q));

endmodule

// File: tb/qbio_port_bench.sv
module qbio_port_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_op = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [2:0] wr_idx = 3'd0;
  logic       rd_en = 1'b0;
  logic       rd_rmw = 1'b0;
  logic [7:0] rd_data;
  logic [7:0] pad_in = 8'hFF;
  logic [7:0] pad_pd_en, pad_pu_strong_en, pad_pu_weak_en;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  qbio_port u_qbio_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op), .wr_data(wr_data),
    .wr_idx(wr_idx), .rd_en(rd_en), .rd_rmw(rd_rmw), .rd_data(rd_data),
    .pad_in(pad_in), .pad_pd_en(pad_pd_en), .pad_pu_strong_en(pad_pu_strong_en),
    .pad_pu_weak_en(pad_pu_weak_en)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench model: a pin reads back only where the latch lets it float
  function automatic logic [7:0] seen(input logic [7:0] lat, input logic [7:0] pin);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = lat[b] ? pin[b] : 1'b0;
    return r;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] v);
    wr_en = 1'b1; wr_op = 2'd0; wr_data = v;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic read_now(input logic rmw);
    rd_en = 1'b1; rd_rmw = rmw;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic check_pads(input string req, input logic [7:0] lat, input logic [7:0] pin);
    chk({req, " pd"},     pad_pd_en,        ~lat);
    chk({req, " weak"},   pad_pu_weak_en,   lat);
    chk({req, " strong"}, pad_pu_strong_en, seen(lat, pin));
  endtask

  initial begin
    logic [7:0] model;
    logic [7:0] held;
    repeat (3) tick();
    // R1 reset state
    chk("R1 rd_data", rd_data, 8'h00);
    check_pads("R1", 8'hFF, 8'hFF);
    rst_n = 1'b1;
    tick();
    read_now(1'b1);
    chk("R1 latch", rd_data, 8'hFF);

    // R2 R5 R6 R7 R8: all latch values against a spread of pin patterns
    for (int l = 0; l < 256; l++) begin
      for (int p = 0; p < 16; p++) begin
        logic [7:0] pv;
        pv = 8'((p * 8'd73) ^ (l >> 1) ^ (p << 4));
        pad_in = pv;
        write_byte(8'(l));
        tick();
        check_pads("R5/R6", 8'(l), pv);
        read_now(1'b0);
        chk("R8 plain read", rd_data, seen(8'(l), pv));
        read_now(1'b1);
        chk("R7 rmw read R2", rd_data, 8'(l));
      end
    end

    // R3 bit set/clear sweep
    pad_in = 8'hFF;
    for (int base = 0; base < 256; base += 51) begin
      for (int i = 0; i < 8; i++) begin
        for (int op = 1; op <= 2; op++) begin
          write_byte(8'(base));
          wr_en = 1'b1; wr_op = 2'(op); wr_idx = 3'(i); wr_data = ~8'(base);
          tick();
          wr_en = 1'b0;
          model = 8'(base);
          model[i] = (op == 1);
          read_now(1'b1);
          chk("R3 bit write", rd_data, model);
        end
      end
    end

    // R4 no-op code and idle strobe
    write_byte(8'h5A);
    wr_en = 1'b1; wr_op = 2'd3; wr_data = 8'h00; wr_idx = 3'd1;
    tick();
    wr_en = 1'b0;
    read_now(1'b1);
    chk("R4 nop code", rd_data, 8'h5A);
    wr_op = 2'd0; wr_data = 8'h00;
    tick();
    read_now(1'b1);
    chk("R4 wr_en low", rd_data, 8'h5A);

    // R9 synchronizer latency
    write_byte(8'hFF);
    pad_in = 8'h0F;
    repeat (3) tick();
    pad_in = 8'hF0;
    read_now(1'b0);
    chk("R9 edge1 old", rd_data, 8'h0F);
    read_now(1'b0);
    chk("R9 edge2 old", rd_data, 8'h0F);
    read_now(1'b0);
    chk("R9 edge3 new", rd_data, 8'hF0);

    // R6 strong pull-up drops and returns
    pad_in = 8'hFF;
    repeat (3) tick();
    chk("R6 high", pad_pu_strong_en, 8'hFF);
    pad_in = 8'hFB;
    tick();
    chk("R6 one edge", pad_pu_strong_en, 8'hFF);
    tick();
    chk("R6 dropped", pad_pu_strong_en, 8'hFB);
    chk("R6 weak stays", pad_pu_weak_en, 8'hFF);
    pad_in = 8'hFF;
    repeat (2) tick();
    chk("R6 restored", pad_pu_strong_en, 8'hFF);

    // R10 hold without strobe
    read_now(1'b0);
    held = rd_data;
    pad_in = 8'h00;
    write_byte(8'h33);
    repeat (4) tick();
    chk("R10 hold", rd_data, held);

    // R11 read alongside write
    wr_en = 1'b1; wr_op = 2'd0; wr_data = 8'hC6;
    rd_en = 1'b1; rd_rmw = 1'b1;
    tick();
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R11 old latch", rd_data, 8'h33);
    read_now(1'b1);
    chk("R11 new latch", rd_data, 8'hC6);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule